// File: doc/BRIEF.md
# Flat-Register Crate Controller Port

This block sits between a host register bus and a crate dataway engine. The host sees a window of thirteen 16-bit registers at even byte offsets. Each one has a fixed role. One register holds the crate address and the cable delay. One loads the station, function and subaddress code. Others stage write data, return read data, set the control modes, report status and fire the initialise, clear and crate-on actions. There is no mode or submode protocol to step through.

Dataway cycles start as a side effect of certain accesses:

- Loading the function code with its start bit set begins a read cycle.
- Writing the low data word begins a write cycle.
- Reading the block-read register returns the latest low word and at once repeats the cycle with the same code.

Each cycle request is a one-clock pulse. A busy flag then holds off further requests until the dataway engine acknowledges with its Q, X and data results.

Top module: `crate_regport`

## Requirements
- R1: After reset, `cyc_req`, `dw_inhibit`, `dw_z`, `dw_c` and `crate_on` are 0. The control status register reads 0x0004 (crate off). The response status register reads 0x0000.
- R2: A write to offset 0x00 stores crate number bits [3:0] and delay bits [7:4]. These drive `geo_crate` and `geo_delay`, and a read of 0x00 returns them in bits [7:0]. The geo register is unchanged by any other access.
- R3: A write to offset 0x02 loads the code word, with N in [4:0], F in [9:5], A in [13:10] and the start bit in [15]. The code fields appear on `cyc_n`, `cyc_f` and `cyc_a`. If bit 15 is 1, `cyc_req` pulses in the next cycle with `cyc_write`=0. If bit 15 is 0, no request is made.
- R4: A write to offset 0x04 stages the high data byte from bits [7:0]. A later write to 0x06 stages the low word and pulses `cyc_req` in the next cycle with `cyc_write`=1 and `cyc_wdata` = {high byte, low word}.
- R5: On an acknowledge while busy, `cyc_rdata` is captured. Offset 0x08 then returns its bits [23:16] in bits [7:0], and offset 0x0A returns bits [15:0].
- R6: A read of offset 0x0C returns the captured low word and starts a new read cycle with the unchanged code. A read of 0x0A starts nothing.
- R7: `cyc_req` is high for exactly one clock. From a request until `cyc_ack`, every trigger is ignored and makes no request.
- R8: Writing to offset 0x0E controls two modes. The value 0x000A sets inhibit and 0x000B clears it. The value 0x000C enables LAM detection and 0x000D disables it. Any other value changes nothing. `dw_inhibit` follows the inhibit state.
- R9: Offset 0x10 reads inhibit in bit 0, LAM enable in bit 1 and crate off in bit 2, with zeros above.
- R10: Offset 0x12 reads Q in bit 0, X in bit 1, and `lam_in` AND LAM enable in bit 2. Q and X come from the last acknowledge.
- R11: Any write to 0x16 pulses `dw_z` for one clock in the next cycle. Any write to 0x14 pulses `dw_c` the same way. Either write sets Q and X to 1.
- R12: Any write to 0x18 sets `crate_on` to 1, and status bit 2 reads 0.
- R13: Reads of unmapped offsets (odd addresses and 0x1A to 0x1E) return 0. Writes to them change no register, output or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_addr | input | 5 | Byte offset within the window |
| host_wr | input | 1 | Host write strobe, one clock per access |
| host_rd | input | 1 | Host read strobe, one clock per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the current address (combinational) |
| geo_crate | output | 4 | Selected crate number, 15 = broadcast |
| geo_delay | output | 4 | Cable delay steps |
| cyc_req | output | 1 | One-clock dataway cycle request |
| cyc_write | output | 1 | 1 = write cycle, 0 = read cycle |
| cyc_n | output | 5 | Station number |
| cyc_f | output | 5 | Function code |
| cyc_a | output | 4 | Subaddress |
| cyc_wdata | output | 24 | Write data for the cycle |
| cyc_ack | input | 1 | Cycle completion strobe |
| cyc_q | input | 1 | Q response, valid with cyc_ack |
| cyc_x | input | 1 | X response, valid with cyc_ack |
| cyc_rdata | input | 24 | Read data, valid with cyc_ack |
| lam_in | input | 1 | Any LAM request from the crate |
| dw_inhibit | output | 1 | Inhibit line state |
| dw_z | output | 1 | Initialise pulse |
| dw_c | output | 1 | Clear pulse |
| crate_on | output | 1 | Crate switched on |

## Verification
The bench builds the block with its defaults: a 5-bit address (`ADDR_W`=5) and two reset synchroniser stages (`RST_SYNC`=2). With the full 5-bit address, every odd byte offset and the three unused even offsets above 0x18 can be driven, so aliasing onto a real register would show. Random code words, data bytes, Q/X values and acknowledge data then go through the write, read and block-read paths. These are mixed with directed cases: a trigger during a busy cycle, mode writes with unknown values, and initialise or clear after a cycle has returned Q=X=0.

// File: rtl/crate_pkg.sv
package crate_pkg;
  localparam int LO_W    = 16;
  localparam int HI_W    = 8;
  localparam int WORD_W  = LO_W + HI_W;
  localparam int N_W     = 5;
  localparam int F_W     = 5;
  localparam int A_W     = 4;
  localparam int CRATE_W = 4;
  localparam int DLY_W   = 4;
  localparam int GEO_W   = CRATE_W + DLY_W;
  localparam int START_BIT = LO_W - 1;

  // register slots; byte offset of slot k is 2*k
  localparam int NREG    = 13;
  localparam int IX_GEO  = 0;
  localparam int IX_NAF  = 1;
  localparam int IX_WHI  = 2;
  localparam int IX_WLO  = 3;
  localparam int IX_RHI  = 4;
  localparam int IX_RLO  = 5;
  localparam int IX_BLK  = 6;
  localparam int IX_MODE = 7;
  localparam int IX_CTL  = 8;
  localparam int IX_STS  = 9;
  localparam int IX_CLR  = 10;
  localparam int IX_INIT = 11;
  localparam int IX_ON   = 12;

  localparam logic [LO_W-1:0] MODE_INH_ON  = 16'h000A;
  localparam logic [LO_W-1:0] MODE_INH_OFF = 16'h000B;
  localparam logic [LO_W-1:0] MODE_LAM_ON  = 16'h000C;
  localparam logic [LO_W-1:0] MODE_LAM_OFF = 16'h000D;

  function automatic int unsigned slot_offset(input int idx);
    return 2 * idx;
  endfunction
endpackage

// File: rtl/crate_decode.sv
module crate_decode
  import crate_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   sel_o,
  output logic              hit_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    assign sel_o[g] = (addr_i == ADDR_W'(slot_offset(g)));
  end

  assign hit_o = |sel_o;
endmodule

// File: rtl/crate_cfg_regs.sv
module crate_cfg_regs
  import crate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [NREG-1:0]   sel_i,
  input  logic [LO_W-1:0]   wdata_i,
  output logic [GEO_W-1:0]  geo_q,
  output logic [LO_W-1:0]   naf_q,
  output logic [HI_W-1:0]   whi_q,
  output logic [LO_W-1:0]   wlo_q,
  output logic              inhibit_q,
  output logic              lam_en_q,
  output logic              crate_off_q
);
  logic [GEO_W-1:0] geo_d;
  logic [LO_W-1:0]  naf_d;
  logic [HI_W-1:0]  whi_d;
  logic [LO_W-1:0]  wlo_d;
  logic             inhibit_d, lam_en_d, crate_off_d;

  always_comb begin
    geo_d       = geo_q;
    naf_d       = naf_q;
    whi_d       = whi_q;
    wlo_d       = wlo_q;
    inhibit_d   = inhibit_q;
    lam_en_d    = lam_en_q;
    crate_off_d = crate_off_q;
    if (wr_en_i) begin
      if (sel_i[IX_GEO]) geo_d = wdata_i[GEO_W-1:0];
      if (sel_i[IX_NAF]) naf_d = wdata_i;
      if (sel_i[IX_WHI]) whi_d = wdata_i[HI_W-1:0];
      if (sel_i[IX_WLO]) wlo_d = wdata_i;
      if (sel_i[IX_ON])  crate_off_d = 1'b0;
      if (sel_i[IX_MODE]) begin
        case (wdata_i)
          MODE_INH_ON:  inhibit_d = 1'b1;
          MODE_INH_OFF: inhibit_d = 1'b0;
          MODE_LAM_ON:  lam_en_d  = 1'b1;
          MODE_LAM_OFF: lam_en_d  = 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      geo_q       <= '0;
      naf_q       <= '0;
      whi_q       <= '0;
      wlo_q       <= '0;
      inhibit_q   <= 1'b0;
      lam_en_q    <= 1'b0;
      crate_off_q <= 1'b1;
    end else begin
      geo_q       <= geo_d;
      naf_q       <= naf_d;
      whi_q       <= whi_d;
      wlo_q       <= wlo_d;
      inhibit_q   <= inhibit_d;
      lam_en_q    <= lam_en_d;
      crate_off_q <= crate_off_d;
    end
  end

  // R2: geo register changes only on its own write
  p_geo_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel_i[IX_GEO]) |=> $stable(geo_q));
  // R8: inhibit code sets the inhibit state
  p_mode_inh_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i[IX_MODE] && wdata_i == MODE_INH_ON) |=> inhibit_q);
  // R12: crate-on write switches the crate on
  p_crate_on_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i[IX_ON]) |=> !crate_off_q);
endmodule

// File: rtl/crate_cycle_ctrl.sv
module crate_cycle_ctrl
  import crate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_rd_i,
  input  logic              trig_wr_i,
  input  logic              qx_force_i,
  input  logic              ack_i,
  input  logic              q_i,
  input  logic              x_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              req_q,
  output logic              write_q,
  output logic              busy_q,
  output logic              q_q,
  output logic              x_q,
  output logic [WORD_W-1:0] word_q
);
  logic              start;
  logic              done;
  logic              req_d, write_d, busy_d, q_d, x_d;
  logic [WORD_W-1:0] word_d;

  assign start = (trig_rd_i | trig_wr_i) & ~busy_q;
  assign done  = busy_q & ack_i;

  always_comb begin
    req_d   = start;
    write_d = start ? trig_wr_i : write_q;
    busy_d  = start | (busy_q & ~ack_i);
    word_d  = done ? rdata_i : word_q;
    q_d     = q_q;
    x_d     = x_q;
    if (qx_force_i) begin
      q_d = 1'b1;
      x_d = 1'b1;
    end else if (done) begin
      q_d = q_i;
      x_d = x_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      write_q <= 1'b0;
      busy_q  <= 1'b0;
      q_q     <= 1'b0;
      x_q     <= 1'b0;
      word_q  <= '0;
    end else begin
      req_q   <= req_d;
      write_q <= write_d;
      busy_q  <= busy_d;
      q_q     <= q_d;
      x_q     <= x_d;
      word_q  <= word_d;
    end
  end

  // R7: request lasts one clock
  p_req_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  // R7: no new request while a cycle is outstanding
  p_busy_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !req_q);
  // R5: acknowledged data is captured
  p_ack_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_i) |=> (word_q == $past(rdata_i)));
  // R11: initialise or clear leaves Q and X at 1
  p_qx_force_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qx_force_i |=> (q_q && x_q));
endmodule

// File: rtl/crate_regport.sv
module crate_regport
  import crate_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [LO_W-1:0]   host_wdata,
  output logic [LO_W-1:0]   host_rdata,
  output logic [CRATE_W-1:0] geo_crate,
  output logic [DLY_W-1:0]  geo_delay,
  output logic              cyc_req,
  output logic              cyc_write,
  output logic [N_W-1:0]    cyc_n,
  output logic [F_W-1:0]    cyc_f,
  output logic [A_W-1:0]    cyc_a,
  output logic [WORD_W-1:0] cyc_wdata,
  input  logic              cyc_ack,
  input  logic              cyc_q,
  input  logic              cyc_x,
  input  logic [WORD_W-1:0] cyc_rdata,
  input  logic              lam_in,
  output logic              dw_inhibit,
  output logic              dw_z,
  output logic              dw_c,
  output logic              crate_on
);
  // reset: asserted asynchronously, released through a synchroniser
  logic [RST_SYNC-1:0] rsync_q;
  logic                rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_SYNC-2:0], 1'b1};
  end
  assign rst_int_n = rsync_q[RST_SYNC-1];

  logic [NREG-1:0]   sel;
  logic              hit;
  logic [GEO_W-1:0]  geo_q;
  logic [LO_W-1:0]   naf_q;
  logic [HI_W-1:0]   whi_q;
  logic [LO_W-1:0]   wlo_q;
  logic              inhibit_q, lam_en_q, crate_off_q;
  logic              busy, q_st, x_st;
  logic [WORD_W-1:0] rd_word;
  logic              trig_rd, trig_wr, qx_force;
  logic              z_q, c_q;

  crate_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (host_addr),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  crate_cfg_regs u_regs (
    .clk_i       (clk),
    .rst_ni      (rst_int_n),
    .wr_en_i     (host_wr),
    .sel_i       (sel),
    .wdata_i     (host_wdata),
    .geo_q       (geo_q),
    .naf_q       (naf_q),
    .whi_q       (whi_q),
    .wlo_q       (wlo_q),
    .inhibit_q   (inhibit_q),
    .lam_en_q    (lam_en_q),
    .crate_off_q (crate_off_q)
  );

  assign trig_rd  = (host_wr & sel[IX_NAF] & host_wdata[START_BIT])
                  | (host_rd & sel[IX_BLK]);
  assign trig_wr  = host_wr & sel[IX_WLO];
  assign qx_force = host_wr & (sel[IX_INIT] | sel[IX_CLR]);

  crate_cycle_ctrl u_cycle (
    .clk_i      (clk),
    .rst_ni     (rst_int_n),
    .trig_rd_i  (trig_rd),
    .trig_wr_i  (trig_wr),
    .qx_force_i (qx_force),
    .ack_i      (cyc_ack),
    .q_i        (cyc_q),
    .x_i        (cyc_x),
    .rdata_i    (cyc_rdata),
    .req_q      (cyc_req),
    .write_q    (cyc_write),
    .busy_q     (busy),
    .q_q        (q_st),
    .x_q        (x_st),
    .word_q     (rd_word)
  );

  // initialise / clear pulses
  logic z_d, c_d;
  always_comb begin
    z_d = host_wr & sel[IX_INIT];
    c_d = host_wr & sel[IX_CLR];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      z_q <= z_d;
      c_q <= c_d;
    end
  end

  // readback
  always_comb begin
    host_rdata = '0;
    if (sel[IX_GEO]) host_rdata = LO_W'(geo_q);
    if (sel[IX_NAF]) host_rdata = naf_q;
    if (sel[IX_RHI]) host_rdata = LO_W'(rd_word[WORD_W-1:LO_W]);
    if (sel[IX_RLO] || sel[IX_BLK]) host_rdata = rd_word[LO_W-1:0];
    if (sel[IX_CTL]) host_rdata = LO_W'({crate_off_q, lam_en_q, inhibit_q});
    if (sel[IX_STS]) host_rdata = LO_W'({lam_in & lam_en_q, x_st, q_st});
  end

  assign geo_crate  = geo_q[CRATE_W-1:0];
  assign geo_delay  = geo_q[GEO_W-1:CRATE_W];
  assign cyc_n      = naf_q[N_W-1:0];
  assign cyc_f      = naf_q[N_W+F_W-1:N_W];
  assign cyc_a      = naf_q[N_W+F_W+A_W-1:N_W+F_W];
  assign cyc_wdata  = {whi_q, wlo_q};
  assign dw_inhibit = inhibit_q;
  assign dw_z       = z_q;
  assign dw_c       = c_q;
  assign crate_on   = ~crate_off_q;

  // R13: unmapped offsets read as zero
  p_unmapped_zero_r13: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_rd && !hit) |-> (host_rdata == '0));
  // R7: a request is never raised while the previous cycle is still open
  p_req_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && !cyc_ack) |=> (busy && !cyc_req));
endmodule

// File: tb/crate_regport_bench.sv
module crate_regport_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  host_addr;
  logic        host_wr, host_rd;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic [3:0]  geo_crate, geo_delay;
  logic        cyc_req, cyc_write;
  logic [4:0]  cyc_n, cyc_f;
  logic [3:0]  cyc_a;
  logic [23:0] cyc_wdata;
  logic        cyc_ack, cyc_q, cyc_x;
  logic [23:0] cyc_rdata;
  logic        lam_in;
  logic        dw_inhibit, dw_z, dw_c, crate_on;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  crate_regport u_crate_regport (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .geo_crate(geo_crate), .geo_delay(geo_delay), .cyc_req(cyc_req),
    .cyc_write(cyc_write), .cyc_n(cyc_n), .cyc_f(cyc_f), .cyc_a(cyc_a),
    .cyc_wdata(cyc_wdata), .cyc_ack(cyc_ack), .cyc_q(cyc_q), .cyc_x(cyc_x),
    .cyc_rdata(cyc_rdata), .lam_in(lam_in), .dw_inhibit(dw_inhibit),
    .dw_z(dw_z), .dw_c(dw_c), .crate_on(crate_on)
  );

  function automatic logic [15:0] pack_code(input logic [4:0] n, input logic [4:0] f,
                                            input logic [3:0] a, input logic s);
    return {s, 1'b0, a, f, n};
  endfunction

  function automatic logic [15:0] exp_resp(input logic q, input logic x, input logic lamp);
    return {13'd0, lamp, x, q};
  endfunction

  function automatic logic [15:0] exp_ctl(input logic inh, input logic len, input logic off);
    return {13'd0, off, len, inh};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic hw(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic ack(input logic q, input logic x, input logic [23:0] d);
    @(negedge clk);
    cyc_ack = 1'b1; cyc_q = q; cyc_x = x; cyc_rdata = d;
    @(negedge clk);
    cyc_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    logic [4:0]  n, f;
    logic [3:0]  a;
    logic [7:0]  geo, hi;
    logic [15:0] lo;
    logic        rq, rx;
    logic [23:0] w;
    int unsigned seed;

    seed = $urandom(32'd4242);
    host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    cyc_ack = 0; cyc_q = 0; cyc_x = 0; cyc_rdata = '0; lam_in = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cyc_req", cyc_req, 0);
    chk("R1 crate_on", crate_on, 0);
    chk("R1 dw_inhibit", dw_inhibit, 0);
    chk("R1 dw_z/dw_c", {dw_z, dw_c}, 0);
    hr(5'h10, rd); chk("R1 control status", rd, 16'h0004);
    hr(5'h12, rd); chk("R1 response status", rd, 16'h0000);

    for (int i = 0; i < 16; i++) begin
      n = 5'($urandom); f = 5'($urandom); a = 4'($urandom);
      geo = 8'($urandom); hi = 8'($urandom); lo = 16'($urandom);
      rq = 1'($urandom); rx = 1'($urandom); w = 24'($urandom);

      hw(5'h00, {8'hC3, geo});
      chk("R2 geo_crate", geo_crate, geo[3:0]);
      chk("R2 geo_delay", geo_delay, geo[7:4]);
      hr(5'h00, rd); chk("R2 geo readback", rd, {8'd0, geo});

      hw(5'h02, pack_code(n, f, a, 1'b0));
      chk("R3 no request with start bit 0", cyc_req, 0);
      hw(5'h04, {8'h5A, hi});
      hw(5'h06, lo);
      chk("R4 write request", cyc_req, 1);
      chk("R4 cyc_write", cyc_write, 1);
      chk("R4 cyc_wdata", cyc_wdata, {hi, lo});
      chk("R3 code fields", {cyc_n, cyc_f, cyc_a}, {n, f, a});
      tick();
      chk("R7 single-clock request", cyc_req, 0);
      hw(5'h06, lo ^ 16'h0001);
      chk("R7 trigger ignored while busy", cyc_req, 0);
      ack(rq, rx, w);
      hr(5'h12, rd); chk("R10 Q/X readback", rd, exp_resp(rq, rx, 1'b0));

      w = 24'($urandom); rq = 1'($urandom); rx = 1'($urandom);
      hw(5'h02, pack_code(n, f, a, 1'b1));
      chk("R3 read request on start bit", cyc_req, 1);
      chk("R3 read direction", cyc_write, 0);
      ack(rq, rx, w);
      hr(5'h08, rd); chk("R5 high byte", rd, {8'd0, w[23:16]});
      hr(5'h0A, rd); chk("R5 low word", rd, w[15:0]);
      chk("R6 low-word read starts nothing", cyc_req, 0);
      hr(5'h12, rd); chk("R10 Q/X after read", rd, exp_resp(rq, rx, 1'b0));
    end

    // R6 block read
    hw(5'h02, pack_code(5'd7, 5'd2, 4'd3, 1'b1));
    ack(1'b1, 1'b0, 24'h11A001);
    hr(5'h0C, rd);
    chk("R6 block word 1", rd, 16'hA001);
    chk("R6 block repeats cycle", cyc_req, 1);
    chk("R6 same code", {cyc_n, cyc_f, cyc_a, cyc_write}, {5'd7, 5'd2, 4'd3, 1'b0});
    ack(1'b1, 1'b0, 24'h22A002);
    hr(5'h0C, rd);
    chk("R6 block word 2", rd, 16'hA002);
    ack(1'b1, 1'b0, 24'h33A003);
    hr(5'h0A, rd);
    chk("R6 final word", rd, 16'hA003);
    chk("R6 final read no cycle", cyc_req, 0);

    // R8 / R9 modes
    hw(5'h0E, 16'h000A);
    chk("R8 inhibit on", dw_inhibit, 1);
    hr(5'h10, rd); chk("R9 inhibit bit", rd, exp_ctl(1, 0, 1));
    hw(5'h0E, 16'h000C);
    hr(5'h10, rd); chk("R9 lam enable bit", rd, exp_ctl(1, 1, 1));
    lam_in = 1'b1;
    hr(5'h12, rd); chk("R10 lam pending", rd, exp_resp(1, 0, 1));
    hw(5'h0E, 16'h0007);
    hw(5'h0E, 16'h010A);
    hr(5'h10, rd); chk("R8 unknown code ignored", rd, exp_ctl(1, 1, 1));
    hw(5'h0E, 16'h000B);
    chk("R8 inhibit off", dw_inhibit, 0);
    hw(5'h0E, 16'h000D);
    hr(5'h10, rd); chk("R9 both cleared", rd, exp_ctl(0, 0, 1));
    hr(5'h12, rd); chk("R10 lam masked", rd, exp_resp(1, 0, 0));
    lam_in = 1'b0;

    // R11 initialise and clear
    hw(5'h02, pack_code(5'd1, 5'd0, 4'd0, 1'b1));
    ack(1'b0, 1'b0, 24'h0);
    hw(5'h16, 16'h1234);
    chk("R11 z pulse", {dw_z, dw_c}, 2'b10);
    tick();
    chk("R11 z pulse ends", dw_z, 0);
    hr(5'h12, rd); chk("R11 Q/X after Z", rd, exp_resp(1, 1, 0));
    hw(5'h02, pack_code(5'd1, 5'd0, 4'd0, 1'b1));
    ack(1'b0, 1'b0, 24'h0);
    hw(5'h14, 16'h0000);
    chk("R11 c pulse", {dw_z, dw_c}, 2'b01);
    hr(5'h12, rd); chk("R11 Q/X after C", rd, exp_resp(1, 1, 0));

    // R12 crate on
    hw(5'h18, 16'hFFFF);
    chk("R12 crate_on", crate_on, 1);
    hr(5'h10, rd); chk("R12 status off bit clear", rd, exp_ctl(0, 0, 0));

    // R13 unmapped offsets
    hw(5'h00, 16'h005A);
    hw(5'h02, pack_code(5'd9, 5'd16, 4'd1, 1'b0));
    foreach (rd[k]) begin end
    for (int k = 0; k < 8; k++) begin
      logic [4:0] ua;
      ua = (k < 3) ? 5'(5'h1A + 2 * k) : 5'(2 * k + 1);
      hw(ua, 16'hFFFF);
      chk("R13 unmapped write no request", cyc_req, 0);
      hr(ua, rd);
      chk("R13 unmapped read zero", rd, 16'h0000);
    end
    hr(5'h00, rd); chk("R13 geo untouched", rd, 16'h005A);
    hr(5'h02, rd); chk("R13 code untouched", rd, pack_code(5'd9, 5'd16, 4'd1, 1'b0));
    hr(5'h10, rd); chk("R13 modes untouched", rd, exp_ctl(0, 0, 0));
    chk("R13 pulses quiet", {dw_z, dw_c, dw_inhibit}, 3'b000);

    finish_run();
  end
endmodule